// File: doc/BRIEF.md
# Receive Descriptor Ring Pointer Engine

This block is the hardware side of a receive descriptor ring held in host memory. Software supplies the ring's base address and the byte offset of its last descriptor, and moves a software pointer as it consumes descriptors. The engine keeps its own fill pointer. For each received frame it writes back the completion fields of the descriptor under that pointer, then moves the pointer on by one 16-byte descriptor. From the last descriptor it wraps back to the base.

The engine never fills the descriptor that the software pointer names. That slot is software's fence: a frame offered while the fill pointer sits on it stays pending and raises a descriptor-empty status bit. Software learns that frames are pending by comparing the exported fill pointer with the slot it will examine next. Memory is reached through a one-outstanding request/grant write port. Payload movement and frame parsing are handled elsewhere.

Top module: `rx_ring_engine`

## Requirements
- R1: After reset the fill pointer output and the status output are zero, no memory write is requested and no frame is accepted.
- R2: A cycle with the load input high sets the fill pointer to the base input in the next cycle.
- R3: An accepted frame produces exactly two word writes, in this order. The first goes to fill pointer + 8 with data {MAC status[15:0], frame length + 3}, the length field sitting in bits 15:0. The second goes to fill pointer + 12 with data {24'b0, DMA status[7:0]}. A request and its address and data hold steady until granted.
- R4: The grant of the second write moves the fill pointer to the next descriptor, 16 bytes on. From base + last-offset it moves to base.
- R5: A frame is accepted only on a cycle with valid and ready both high. Ready is low while the fill pointer equals the software pointer. A frame offered in that state sets status bit 5 and leaves the fill pointer unchanged.
- R6: The grant of the second write sets status bit 0, the write-back-complete flag.
- R7: Status bits are cleared by writing 1 to the matching clear input bit. Bits with a 0 in the clear input keep their value, and a set and a clear in the same cycle leave the bit set.
- R8: Frame lengths from 64 to 10318 bytes are all accepted with no length check. A 10318-byte frame writes back 10321 in the length field.
- R9: A load while a write-back is in progress abandons it. The request drops the next cycle, the fill pointer takes the base input, and bit 0 is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_base_i | input | AW | Ring base byte address |
| cfg_last_i | input | AW | Byte offset of the last descriptor, 16 x (N-1) |
| cfg_load_i | input | 1 | Reload the fill pointer from the base |
| sw_ptr_we_i | input | 1 | Write strobe for the software pointer |
| sw_ptr_i | input | AW | New software pointer |
| frame_valid_i | input | 1 | Frame completion offered |
| frame_ready_o | output | 1 | Engine can take the frame |
| frame_len_i | input | LW | Frame length in bytes, FCS included |
| frame_mac_stat_i | input | 16 | MAC status for the descriptor |
| frame_dma_stat_i | input | 8 | DMA status for the descriptor |
| mem_req_o | output | 1 | Write request |
| mem_addr_o | output | AW | Write byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_gnt_i | input | 1 | Write grant |
| hw_ptr_o | output | AW | Fill pointer, readable by software |
| int_stat_o | output | 6 | Sticky status: bit 0 write-back complete, bit 5 descriptor empty |
| int_clr_i | input | 6 | Write-1-to-clear for the status |

## Verification
A corrupted fill pointer shows on the next write-back address, at most one frame later. It also shows on hw_ptr_o, which the bench compares after every completion against a slot index kept modulo the ring size. A wrong fence comparison shows within the same cycle as a ready level that disagrees with the modelled software pointer. A wrong wrap point shows within one lap of the ring as an out-of-ring address. The bench sweeps ring sizes 2 to 5, moves the software pointer by varying amounts, and varies grant latency. This exposes both stalls that should not happen and overruns into the fenced slot.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int DESC_BYTES = 16;
  localparam int OFF_WC     = 8;
  localparam int OFF_DMA    = 12;
  localparam int ST_W       = 6;
  localparam int ST_DONE    = 0;
  localparam int ST_EMPTY   = 5;
  localparam int WD_W       = 32;

  typedef enum logic [1:0] {
    WB_IDLE = 2'd0,
    WB_WC   = 2'd1,
    WB_DMA  = 2'd2
  } wb_state_e;
endpackage

// File: rtl/rx_ring_next.sv
module rx_ring_next
  import rx_ring_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cur_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] last_i,
  output logic [AW-1:0] nxt_o
);
  logic [AW-1:0] last_slot;
  assign last_slot = base_i + last_i;
  assign nxt_o = (cur_i == last_slot) ? base_i : cur_i + AW'(DESC_BYTES);
endmodule

// File: rtl/rx_wb_seq.sv
module rx_wb_seq
  import rx_ring_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 14
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            abort_i,
  input  logic [AW-1:0]   slot_i,
  input  logic [LW-1:0]   len_i,
  input  logic [15:0]     mac_stat_i,
  input  logic [7:0]      dma_stat_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            mem_req_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [WD_W-1:0] mem_wdata_o,
  input  logic            mem_gnt_i
);
  localparam int PADW = 16 - LW;

  wb_state_e     state_q;
  logic [AW-1:0] slot_q;
  logic [LW-1:0] len_q;
  logic [15:0]   mac_q;
  logic [7:0]    dma_q;
  logic [15:0]   wc;

  assign wc = {{PADW{1'b0}}, len_q} + 16'd3;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WB_IDLE;
      slot_q  <= '0;
      len_q   <= '0;
      mac_q   <= '0;
      dma_q   <= '0;
    end else if (abort_i) begin
      state_q <= WB_IDLE;
    end else begin
      unique case (state_q)
        WB_IDLE: if (start_i) begin
          state_q <= WB_WC;
          slot_q  <= slot_i;
          len_q   <= len_i;
          mac_q   <= mac_stat_i;
          dma_q   <= dma_stat_i;
        end
        WB_WC:   if (mem_gnt_i) state_q <= WB_DMA;
        WB_DMA:  if (mem_gnt_i) state_q <= WB_IDLE;
        default: state_q <= WB_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_q)
      WB_WC: begin
        mem_addr_o  = slot_q + AW'(OFF_WC);
        mem_wdata_o = {mac_q, wc};
      end
      WB_DMA: begin
        mem_addr_o  = slot_q + AW'(OFF_DMA);
        mem_wdata_o = {24'd0, dma_q};
      end
      default: ;
    endcase
  end

  assign busy_o    = (state_q != WB_IDLE);
  assign mem_req_o = busy_o;
  assign done_o    = (state_q == WB_DMA) && mem_gnt_i && !abort_i;

  // R3: an ungranted request keeps its address and data
  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i && !abort_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o)));

  // R3: the second beat lands 4 bytes above the first
  p_beat_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WB_WC && mem_gnt_i && !abort_i) |=>
      (mem_addr_o == $past(mem_addr_o) + AW'(4)));

  // R9: abort drops the request at once
  p_abort_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !mem_req_o);
endmodule

// File: rtl/rx_int_stat.sv
module rx_int_stat
  import rx_ring_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ST_W-1:0] set_i,
  input  logic [ST_W-1:0] clr_i,
  output logic [ST_W-1:0] stat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_o <= '0;
    else         stat_o <= (stat_o & ~clr_i) | set_i;
  end

  // R7: a set beats a simultaneous clear
  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((stat_o & $past(set_i)) == $past(set_i)));

  // R7: bits not cleared and not set keep their value
  p_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && clr_i == '0) |=> $stable(stat_o));
endmodule

// File: rtl/rx_ring_engine.sv
module rx_ring_engine
  import rx_ring_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 14
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   cfg_base_i,
  input  logic [AW-1:0]   cfg_last_i,
  input  logic            cfg_load_i,
  input  logic            sw_ptr_we_i,
  input  logic [AW-1:0]   sw_ptr_i,
  input  logic            frame_valid_i,
  output logic            frame_ready_o,
  input  logic [LW-1:0]   frame_len_i,
  input  logic [15:0]     frame_mac_stat_i,
  input  logic [7:0]      frame_dma_stat_i,
  output logic            mem_req_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [WD_W-1:0] mem_wdata_o,
  input  logic            mem_gnt_i,
  output logic [AW-1:0]   hw_ptr_o,
  output logic [ST_W-1:0] int_stat_o,
  input  logic [ST_W-1:0] int_clr_i
);
  logic [AW-1:0]   hw_q, sw_q, hw_nxt;
  logic            busy, done, start, fenced, empty_hit;
  logic [ST_W-1:0] st_set;

  rx_ring_next #(.AW(AW)) u_next (
    .cur_i (hw_q),
    .base_i(cfg_base_i),
    .last_i(cfg_last_i),
    .nxt_o (hw_nxt)
  );

  assign fenced        = (hw_q == sw_q);
  assign frame_ready_o = !busy && !fenced && !cfg_load_i;
  assign start         = frame_valid_i && frame_ready_o;
  assign empty_hit     = frame_valid_i && !busy && fenced && !cfg_load_i;

  rx_wb_seq #(.AW(AW), .LW(LW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .abort_i    (cfg_load_i),
    .slot_i     (hw_q),
    .len_i      (frame_len_i),
    .mac_stat_i (frame_mac_stat_i),
    .dma_stat_i (frame_dma_stat_i),
    .busy_o     (busy),
    .done_o     (done),
    .mem_req_o  (mem_req_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_gnt_i  (mem_gnt_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hw_q <= '0;
      sw_q <= '0;
    end else begin
      if (cfg_load_i) hw_q <= cfg_base_i;
      else if (done)  hw_q <= hw_nxt;
      if (sw_ptr_we_i) sw_q <= sw_ptr_i;
    end
  end

  always_comb begin
    st_set           = '0;
    st_set[ST_DONE]  = done;
    st_set[ST_EMPTY] = empty_hit;
  end

  rx_int_stat u_stat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (st_set),
    .clr_i (int_clr_i),
    .stat_o(int_stat_o)
  );

  assign hw_ptr_o = hw_q;

  // R2: load takes the base
  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load_i |=> (hw_ptr_o == $past(cfg_base_i)));

  // R4: outside a load the pointer only steps one descriptor or wraps to base
  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_load_i && done) |=>
      (hw_ptr_o == $past(hw_ptr_o) + AW'(DESC_BYTES) || hw_ptr_o == $past(cfg_base_i)));

  // R5: a fenced offer flags empty and holds the pointer
  p_fence_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && !frame_ready_o && !mem_req_o && !cfg_load_i) |=>
      (int_stat_o[ST_EMPTY] && $stable(hw_ptr_o)));

  // R6: each completed write-back flags done
  p_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_gnt_i && mem_addr_o == hw_ptr_o + AW'(OFF_DMA) && !cfg_load_i) |=>
      int_stat_o[ST_DONE]);
endmodule

// File: tb/rx_ring_engine_tb.sv
`timescale 1ns/1ps
module rx_ring_engine_tb;
  localparam int AW = 32;
  localparam int LW = 14;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] cfg_base_i = '0, cfg_last_i = '0, sw_ptr_i = '0;
  logic          cfg_load_i = 1'b0, sw_ptr_we_i = 1'b0, frame_valid_i = 1'b0, mem_gnt_i = 1'b0;
  logic [LW-1:0] frame_len_i = '0;
  logic [15:0]   frame_mac_stat_i = '0;
  logic [7:0]    frame_dma_stat_i = '0;
  logic [5:0]    int_clr_i = '0;
  logic          frame_ready_o, mem_req_o;
  logic [AW-1:0] mem_addr_o, hw_ptr_o;
  logic [31:0]   mem_wdata_o;
  logic [5:0]    int_stat_o;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  rx_ring_engine #(.AW(AW), .LW(LW)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic clr_stat(input logic [5:0] m);
    int_clr_i = m;
    tick();
    int_clr_i = '0;
  endtask

  // one frame through both write-back beats
  task automatic send(input int len, input logic [15:0] ms, input logic [7:0] ds, input int dly,
                      input logic [31:0] slot, input logic [31:0] nxt, input bit clr_same);
    logic [31:0] wc;
    wc = 32'(len + 3);
    frame_valid_i = 1'b1; frame_len_i = LW'(len); frame_mac_stat_i = ms; frame_dma_stat_i = ds;
    chk(frame_ready_o == 1'b1, "R5 ready when open", 32'(frame_ready_o), 1);
    tick();
    frame_valid_i = 1'b0;
    chk(mem_req_o && mem_addr_o == slot + 8, "R3 first beat addr", mem_addr_o, slot + 8);
    chk(mem_wdata_o == {ms, wc[15:0]}, "R3 R8 first beat data", mem_wdata_o, {ms, wc[15:0]});
    for (int i = 0; i < dly; i++) begin
      tick();
      chk(mem_req_o && mem_addr_o == slot + 8, "R3 hold first beat", mem_addr_o, slot + 8);
    end
    mem_gnt_i = 1'b1;
    tick();
    mem_gnt_i = 1'b0;
    chk(mem_req_o && mem_addr_o == slot + 12, "R3 second beat addr", mem_addr_o, slot + 12);
    chk(mem_wdata_o == {24'd0, ds}, "R3 second beat data", mem_wdata_o, {24'd0, ds});
    for (int i = 0; i < dly; i++) begin
      tick();
      chk(mem_req_o && mem_wdata_o == {24'd0, ds}, "R3 hold second beat", mem_wdata_o, {24'd0, ds});
    end
    mem_gnt_i = 1'b1;
    if (clr_same) int_clr_i = 6'h01;
    tick();
    mem_gnt_i = 1'b0; int_clr_i = '0;
    chk(!mem_req_o, "R3 two beats only", 32'(mem_req_o), 0);
    chk(hw_ptr_o == nxt, "R4 pointer advance", hw_ptr_o, nxt);
    chk(int_stat_o[0], clr_same ? "R7 set wins over clear" : "R6 done flag", 32'(int_stat_o), 1);
    clr_stat(6'h01);
    chk(int_stat_o[0] == 1'b0, "R7 clear done", 32'(int_stat_o), 0);
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] base, last;
    @(negedge clk_i); @(negedge clk_i);
    chk(hw_ptr_o == 0, "R1 pointer reset", hw_ptr_o, 0);
    chk(int_stat_o == 0, "R1 status reset", 32'(int_stat_o), 0);
    chk(!mem_req_o && !frame_ready_o, "R1 idle reset", {30'd0, mem_req_o, frame_ready_o}, 0);
    rst_ni = 1'b1;
    tick();

    for (int n = 2; n <= 5; n++) begin
      int hw_idx, sw_idx, f;
      base = 32'h2000 + 32'(n) * 32'h100;
      last = 32'(16 * (n - 1));
      cfg_base_i = base; cfg_last_i = last;
      cfg_load_i = 1'b1;
      tick();
      cfg_load_i = 1'b0;
      chk(hw_ptr_o == base, "R2 load base", hw_ptr_o, base);
      hw_idx = 0; sw_idx = 1;
      sw_ptr_we_i = 1'b1; sw_ptr_i = base + 16;
      tick();
      sw_ptr_we_i = 1'b0;
      clr_stat(6'h3f);
      f = 0;
      for (int it = 0; it < 4 * n + 2; it++) begin
        if (hw_idx == sw_idx) begin
          frame_valid_i = 1'b1;
          chk(!frame_ready_o, "R5 fenced not ready", 32'(frame_ready_o), 0);
          tick();
          frame_valid_i = 1'b0;
          chk(int_stat_o[5], "R5 empty flag", 32'(int_stat_o), 32'h20);
          chk(hw_ptr_o == base + 32'(16 * hw_idx), "R5 pointer held", hw_ptr_o, base + 32'(16 * hw_idx));
          chk(!mem_req_o, "R5 no write when fenced", 32'(mem_req_o), 0);
          clr_stat(6'h20);
          chk(int_stat_o == 0, "R7 clear empty", 32'(int_stat_o), 0);
          sw_idx = (sw_idx + 1 + (it % (n - 1))) % n;
          sw_ptr_we_i = 1'b1; sw_ptr_i = base + 32'(16 * sw_idx);
          tick();
          sw_ptr_we_i = 1'b0;
        end else begin
          send(64 + ((f * 997 + n * 131) % 10255), 16'hA500 ^ 16'(f), 8'(f + n), f % 3,
               base + 32'(16 * hw_idx), base + 32'(16 * ((hw_idx + 1) % n)), (f == 3));
          hw_idx = (hw_idx + 1) % n;
          f++;
        end
      end
    end

    // length boundaries, 4-slot ring with a far fence
    base = 32'h8000; cfg_base_i = base; cfg_last_i = 32'd48;
    cfg_load_i = 1'b1; tick(); cfg_load_i = 1'b0;
    sw_ptr_we_i = 1'b1; sw_ptr_i = base + 48; tick(); sw_ptr_we_i = 1'b0;
    send(64, 16'h0001, 8'h11, 0, base, base + 16, 1'b0);
    send(10318, 16'h0002, 8'h22, 1, base + 16, base + 32, 1'b0);

    // load during a write-back
    frame_valid_i = 1'b1; frame_len_i = LW'(100);
    tick();
    frame_valid_i = 1'b0;
    chk(mem_req_o, "R9 write in progress", 32'(mem_req_o), 1);
    cfg_base_i = 32'h9000; cfg_load_i = 1'b1;
    tick();
    cfg_load_i = 1'b0;
    chk(!mem_req_o, "R9 request dropped", 32'(mem_req_o), 0);
    chk(hw_ptr_o == 32'h9000, "R9 pointer reloaded", hw_ptr_o, 32'h9000);
    chk(int_stat_o[0] == 1'b0, "R9 no done flag", 32'(int_stat_o), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule